// File: doc/BRIEF.md
# Early-Start Transmit FIFO Gate

This block sits between a DMA engine that writes packet bytes and a line-side serializer that pulls them. It buffers up to 2048 bytes and decides when the line side may begin sending the current packet. Each packet begins with a start pulse that carries the packet's byte length and a 6-bit threshold code. Line transmission is released as soon as the buffered byte count reaches the coded threshold, or sooner if every byte of the packet has already been written.

Only one packet is handled at a time. The write side is throttled with a ready/valid handshake. The read side sees a byte-valid flag and a last-byte marker. If the line side asks for a byte while the FIFO is empty and the packet is still incomplete, the packet is marked as underrun. Such a packet still runs to completion, and its final status reports it as not OK.

Top module: `tx_early_gate`

## Requirements
- R1: After reset, pkt_active_o, wr_ready_o, rd_valid_o, rd_last_o, start_tx_o, underrun_o, done_o and ok_o are all 0.
- R2: A pkt_start_i pulse is accepted only when pkt_active_o is 0 and pkt_len_i is nonzero. Accepting it latches the length and the threshold code, sets pkt_active_o on the next cycle and clears underrun_o. In all other cases the pulse is ignored.
- R3: wr_ready_o equals pkt_active_o and FIFO not full (2048 bytes) and bytes written for this packet less than the latched length. A byte is stored when wr_valid_i and wr_ready_o are both 1.
- R4: The threshold code decodes as follows: 0 gives 8 bytes, and a code n from 1 to 63 gives n*32 bytes. Any decoded value above the 2048-byte capacity is clamped to 2048.
- R5: start_tx_o rises one cycle after the buffered byte count is at least the threshold, or one cycle after all bytes of the packet have been written, whichever happens first. It then stays high until the last byte is read.
- R6: rd_valid_o equals start_tx_o and FIFO not empty. rd_data_o presents the bytes in the order they were written. rd_last_o is high when rd_valid_o is high and the byte shown is byte number length-1 of the packet. A read happens when rd_en_i and rd_valid_o are both 1.
- R7: After the read of the last byte, start_tx_o and pkt_active_o drop on the next cycle. done_o pulses for exactly that one cycle.
- R8: underrun_o is set the cycle after a cycle in which start_tx_o=1, rd_en_i=1, the FIFO is empty and the packet is not fully written. It stays set until the next accepted start.
- R9: An underrun packet still completes. ok_o is high only during the done_o cycle, and only if no underrun occurred for that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_start_i | input | 1 | Start-of-packet pulse |
| pkt_len_i | input | 13 | Packet length in bytes |
| thr_code_i | input | 6 | Early-start threshold code |
| pkt_active_o | output | 1 | A packet is being gated |
| wr_valid_i | input | 1 | Write byte valid |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write side may transfer |
| rd_en_i | input | 1 | Line side takes a byte |
| rd_data_o | output | 8 | Byte at FIFO head |
| rd_valid_o | output | 1 | Head byte available to line side |
| rd_last_o | output | 1 | Head byte is the packet's last |
| start_tx_o | output | 1 | Line transmission enabled |
| underrun_o | output | 1 | Current/last packet underran |
| done_o | output | 1 | One-cycle packet-finished pulse |
| ok_o | output | 1 | Finished packet had no underrun |

## Verification
On every cycle the assertions check several invariants. The fill level never passes capacity, and writes are refused while idle. A valid read byte implies that transmission has started, and rd_last_o implies rd_valid_o. start_tx_o holds until the final read, after which it drops together with a one-cycle done_o. underrun_o is sticky, and ok_o never coincides with an underrun. Other behaviour can only be shown by the bench scenarios: the exact cycle at which the coded threshold or a complete packet releases transmission, the data order through a FIFO that wraps for packets longer than 2 KB, the write stall when the FIFO is full, and the fact that an underrun really occurs when writes are starved.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int unsigned LEN_W      = 13;
  localparam int unsigned CODE_W     = 6;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FIFO_DEPTH = 2048;
  localparam int unsigned THR_UNIT   = 32;
  localparam int unsigned THR_MIN    = 8;
endpackage

// File: rtl/txg_thresh.sv
module txg_thresh #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned UNIT   = 32,
  parameter int unsigned MINB   = 8,
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned THR_W  = 12
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [THR_W-1:0]  thr_o
);
  localparam int unsigned RAW_MAX = ((1 << CODE_W) - 1) * UNIT;

  logic [31:0] raw;
  assign raw = (code_i == '0) ? 32'(MINB) : 32'(code_i) * 32'(UNIT);

  generate
    if (RAW_MAX > DEPTH) begin : g_clamp
      assign thr_o = (raw > 32'(DEPTH)) ? THR_W'(DEPTH) : THR_W'(raw);
    end else begin : g_pass
      assign thr_o = THR_W'(raw);
    end
  endgenerate
endmodule

// File: rtl/txg_fifo.sv
module txg_fifo #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en_i) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      if (rd_en_i) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      case ({wr_en_i, rd_en_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem[rptr_q];
  assign count_o   = cnt_q;
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl #(
  parameter int unsigned LEN_W = 13,
  parameter int unsigned CW    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_start_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [CW-1:0]    thr_i,
  input  logic             wr_valid_i,
  input  logic             rd_en_i,
  input  logic [CW-1:0]    fill_i,
  input  logic             full_i,
  input  logic             empty_i,
  output logic             active_o,
  output logic             wr_ready_o,
  output logic             wr_fire_o,
  output logic             rd_valid_o,
  output logic             rd_fire_o,
  output logic             rd_last_o,
  output logic             start_tx_o,
  output logic             underrun_o,
  output logic             done_o,
  output logic             ok_o
);
  logic             active_q, start_q, und_q, done_q, ok_q;
  logic [LEN_W-1:0] len_q, wcnt_q, rcnt_q;
  logic [CW-1:0]    thr_q;
  logic             accept, all_written, starve, pkt_end;

  assign accept      = pkt_start_i && !active_q && (pkt_len_i != '0);
  assign all_written = (wcnt_q == len_q);
  assign wr_ready_o  = active_q && !full_i && !all_written;
  assign wr_fire_o   = wr_valid_i && wr_ready_o;
  assign rd_valid_o  = start_q && !empty_i;
  assign rd_fire_o   = rd_en_i && rd_valid_o;
  assign rd_last_o   = rd_valid_o && (rcnt_q == len_q - LEN_W'(1));
  assign pkt_end     = rd_en_i && rd_last_o;
  // line asks for a byte the DMA has not yet delivered
  assign starve      = start_q && rd_en_i && empty_i && !all_written;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      und_q    <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      len_q    <= '0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
      thr_q    <= '0;
    end else begin
      done_q <= pkt_end;
      ok_q   <= pkt_end && !und_q;
      if (accept) begin
        active_q <= 1'b1;
        start_q  <= 1'b0;
        und_q    <= 1'b0;
        len_q    <= pkt_len_i;
        thr_q    <= thr_i;
        wcnt_q   <= '0;
        rcnt_q   <= '0;
      end else if (active_q) begin
        if (wr_fire_o) wcnt_q <= wcnt_q + LEN_W'(1);
        if (rd_fire_o) rcnt_q <= rcnt_q + LEN_W'(1);
        if (starve) und_q <= 1'b1;
        if (pkt_end) begin
          active_q <= 1'b0;
          start_q  <= 1'b0;
        end else if ((fill_i >= thr_q) || all_written) begin
          start_q <= 1'b1;
        end
      end
    end
  end

  assign active_o   = active_q;
  assign start_tx_o = start_q;
  assign underrun_o = und_q;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
endmodule

// File: rtl/tx_early_gate.sv
module tx_early_gate
  import txg_pkg::*;
#(
  parameter int unsigned P_LEN_W  = LEN_W,
  parameter int unsigned P_CODE_W = CODE_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_DEPTH  = FIFO_DEPTH,
  parameter int unsigned P_UNIT   = THR_UNIT,
  parameter int unsigned P_MINB   = THR_MIN
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pkt_start_i,
  input  logic [P_LEN_W-1:0]  pkt_len_i,
  input  logic [P_CODE_W-1:0] thr_code_i,
  output logic                pkt_active_o,
  input  logic                wr_valid_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  output logic                wr_ready_o,
  input  logic                rd_en_i,
  output logic [P_DATA_W-1:0] rd_data_o,
  output logic                rd_valid_o,
  output logic                rd_last_o,
  output logic                start_tx_o,
  output logic                underrun_o,
  output logic                done_o,
  output logic                ok_o
);
  localparam int unsigned CW = $clog2(P_DEPTH) + 1;

  logic [CW-1:0] thr_dec, fifo_cnt;
  logic          fifo_full, fifo_empty, wr_fire, rd_fire;

  txg_thresh #(
    .CODE_W(P_CODE_W), .UNIT(P_UNIT), .MINB(P_MINB), .DEPTH(P_DEPTH), .THR_W(CW)
  ) u_thresh (
    .code_i(thr_code_i),
    .thr_o (thr_dec)
  );

  txg_fifo #(.DEPTH(P_DEPTH), .DATA_W(P_DATA_W)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_fire),
    .wr_data_i(wr_data_i),
    .rd_en_i  (rd_fire),
    .rd_data_o(rd_data_o),
    .count_o  (fifo_cnt),
    .full_o   (fifo_full),
    .empty_o  (fifo_empty)
  );

  txg_ctrl #(.LEN_W(P_LEN_W), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_start_i(pkt_start_i),
    .pkt_len_i  (pkt_len_i),
    .thr_i      (thr_dec),
    .wr_valid_i (wr_valid_i),
    .rd_en_i    (rd_en_i),
    .fill_i     (fifo_cnt),
    .full_i     (fifo_full),
    .empty_i    (fifo_empty),
    .active_o   (pkt_active_o),
    .wr_ready_o (wr_ready_o),
    .wr_fire_o  (wr_fire),
    .rd_valid_o (rd_valid_o),
    .rd_fire_o  (rd_fire),
    .rd_last_o  (rd_last_o),
    .start_tx_o (start_tx_o),
    .underrun_o (underrun_o),
    .done_o     (done_o),
    .ok_o       (ok_o)
  );
endmodule

// File: rtl/tx_early_gate_chk.sv
module tx_early_gate_chk #(
  parameter int unsigned LEN_W = 13,
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned CW    = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_start_i,
  input logic [LEN_W-1:0] pkt_len_i,
  input logic             pkt_active_o,
  input logic             wr_ready_o,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic             rd_last_o,
  input logic             start_tx_o,
  input logic             underrun_o,
  input logic             done_o,
  input logic             ok_o,
  input logic [CW-1:0]    fill
);
  logic acc;
  assign acc = pkt_start_i && !pkt_active_o && (pkt_len_i != '0);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= CW'(DEPTH));
  a_r3_idle_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_active_o |-> !wr_ready_o);
  a_r6_valid_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> start_tx_o);
  a_r6_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);
  a_r5_start_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_tx_o && !(rd_en_i && rd_last_o)) |=> start_tx_o);
  a_r7_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_last_o) |=> (!start_tx_o && !pkt_active_o && done_o));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_start_clears_und: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (pkt_active_o && !underrun_o && !start_tx_o));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !acc) |=> underrun_o);
  a_r9_ok_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (done_o && !underrun_o));
endmodule

bind tx_early_gate tx_early_gate_chk #(
  .LEN_W(P_LEN_W), .DEPTH(P_DEPTH), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_start_i (pkt_start_i),
  .pkt_len_i   (pkt_len_i),
  .pkt_active_o(pkt_active_o),
  .wr_ready_o  (wr_ready_o),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .rd_last_o   (rd_last_o),
  .start_tx_o  (start_tx_o),
  .underrun_o  (underrun_o),
  .done_o      (done_o),
  .ok_o        (ok_o),
  .fill        (fifo_cnt)
);

// File: tb/tx_early_gate_bench.sv
`timescale 1ns/1ps
module tx_early_gate_bench;
  localparam int DEPTH = 2048;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pkt_start_i = 1'b0;
  logic [12:0] pkt_len_i = '0;
  logic [5:0]  thr_code_i = '0;
  logic        pkt_active_o;
  logic        wr_valid_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_ready_o;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o, rd_last_o, start_tx_o, underrun_o, done_o, ok_o;

  always #4 clk_i = ~clk_i;

  tx_early_gate u_tx_early_gate (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // reference state, built from the requirements
  bit        m_active, m_start, m_und, m_done, m_ok;
  int        m_len, m_thr, m_wcnt, m_rcnt, m_fill;
  logic [7:0] m_q[$];
  bit        saw_und_done;

  function automatic int thr_of(int code);
    int t;
    t = (code == 0) ? 8 : code * 32;
    return (t > DEPTH) ? DEPTH : t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // one clock: drive, compare at mid-cycle, then advance the model
  task automatic step(bit st, int len, int code, bit wv, bit re);
    bit exp_ready, exp_rv, exp_last, wf, rf, acc, starve, last;
    @(negedge clk_i);
    cyc++;
    pkt_start_i = st;
    pkt_len_i   = 13'(len);
    thr_code_i  = 6'(code);
    wr_valid_i  = wv;
    wr_data_i   = 8'($urandom);
    rd_en_i     = re;
    #1;
    exp_ready = m_active && (m_fill < DEPTH) && (m_wcnt < m_len);
    exp_rv    = m_start && (m_fill > 0);
    exp_last  = exp_rv && (m_rcnt == m_len - 1);
    chk("R2 pkt_active", 32'(pkt_active_o), 32'(m_active));
    chk("R3 wr_ready", 32'(wr_ready_o), 32'(exp_ready));
    chk("R4/R5 start_tx", 32'(start_tx_o), 32'(m_start));
    chk("R6 rd_valid", 32'(rd_valid_o), 32'(exp_rv));
    chk("R6 rd_last", 32'(rd_last_o), 32'(exp_last));
    if (exp_rv) chk("R6 rd_data", 32'(rd_data_o), 32'(m_q[0]));
    chk("R8 underrun", 32'(underrun_o), 32'(m_und));
    chk("R7 done", 32'(done_o), 32'(m_done));
    chk("R9 ok", 32'(ok_o), 32'(m_ok));
    if (done_o && underrun_o) saw_und_done = 1;
    wf     = wv && exp_ready;
    rf     = re && exp_rv;
    acc    = st && !m_active && (len != 0);
    starve = m_start && re && (m_fill == 0) && (m_wcnt < m_len);
    last   = rf && exp_last;
    @(posedge clk_i);
    m_done = last;
    m_ok   = last && !m_und;
    if (acc) begin
      m_active = 1; m_start = 0; m_und = 0;
      m_len = len; m_thr = thr_of(code);
      m_wcnt = 0; m_rcnt = 0;
    end else if (m_active) begin
      if (wf) begin m_q.push_back(wr_data_i); m_wcnt++; m_fill++; end
      if (rf) begin void'(m_q.pop_front()); m_rcnt++; m_fill--; end
      if (starve) m_und = 1;
      if (last) begin m_active = 0; m_start = 0; end
      else if ((m_fill - (wf ? 1 : 0) + (rf ? 1 : 0)) >= m_thr ||
               (m_wcnt - (wf ? 1 : 0)) == m_len) m_start = 1;
    end
  endtask

  // hold_rd: no reads until the FIFO is full; inject: spurious starts mid-packet
  task automatic run_pkt(int len, int code, int wr_pct, int rd_pct, bit hold_rd, bit inject);
    bit held;
    int guard;
    held = hold_rd;
    step(1, len, code, 0, 0);
    guard = 0;
    while ((m_active || m_done) && guard < 30000) begin
      bit wv, re, st;
      if (held && m_fill == DEPTH) held = 0;
      wv = ($urandom % 100) < wr_pct;
      re = !held && (($urandom % 100) < rd_pct);
      st = inject && (($urandom % 16) == 0);
      step(st, 1 + ($urandom % 100), $urandom % 64, wv, re);
      guard++;
    end
    if (guard >= 30000) chk("R7 packet completes", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_active = 0; m_start = 0; m_und = 0; m_done = 0; m_ok = 0;
    m_len = 0; m_thr = 0; m_wcnt = 0; m_rcnt = 0; m_fill = 0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 active", 32'(pkt_active_o), 0);
    chk("R1 wr_ready", 32'(wr_ready_o), 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);
    chk("R1 rd_last", 32'(rd_last_o), 0);
    chk("R1 start_tx", 32'(start_tx_o), 0);
    chk("R1 underrun", 32'(underrun_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 ok", 32'(ok_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 zero length is ignored
    step(1, 0, 3, 1, 1);
    step(0, 0, 0, 0, 0);
    chk("R2 len0 ignored", 32'(pkt_active_o), 0);

    // R4 minimum threshold code, full-rate both sides
    run_pkt(100, 0, 100, 100, 0, 0);
    // R4 threshold 32*5=160 with slow reads
    run_pkt(400, 5, 100, 30, 0, 0);
    // R5 packet shorter than threshold releases on completion
    run_pkt(5, 10, 100, 100, 0, 0);
    run_pkt(1, 63, 100, 100, 0, 0);
    // R8/R9 starved writes force underrun, packet still completes
    saw_und_done = 0;
    run_pkt(200, 0, 15, 100, 0, 0);
    chk("R8/R9 underrun packet completed not ok", 32'(saw_und_done), 1);
    // R3 long packet fills the FIFO while reads are held, then wraps
    run_pkt(3000, 63, 100, 50, 1, 0);
    // R2 starts during an active packet are ignored
    run_pkt(300, 2, 60, 60, 0, 1);
    // random mix
    for (int i = 0; i < 25; i++)
      run_pkt(1 + ($urandom % 700), $urandom % 64, 20 + ($urandom % 81),
              20 + ($urandom % 81), 0, ($urandom % 4) == 0);
    repeat (2) step(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule